// File: doc/BRIEF.md
# Dual-Mode 3D Mesh Route Selector

This unit makes the routing decision at each hop of a three-dimensional mesh whose routers have seven ports: local, the four lateral directions and one up and one down. It looks at the router's own coordinate and at the head flit's destination coordinate, source layer and mode bit. From these it picks exactly one output port and presents that choice as a registered one-hot vector with a valid flag. The choice applies to the head flit only. Body flits follow the head's port under wormhole switching, and that is handled outside this unit.

Each packet carries one mode bit, so a packet has exactly two possible paths. With the bit clear (lateral-first), the packet completes X, then Y, inside its source layer, and only then moves vertically to the destination layer. With the bit set (downward), the packet first drops to the bottom layer, z = 0. It routes X then Y there and then climbs to the destination layer. A packet that starts on the bottom layer in downward mode behaves like plain XY routing followed by upward hops.

The coordinate convention is as follows. East is +x, west is -x, north is +y, south is -y, up is +z and down is -z.

Top module: `dm3d_route_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `out_valid` is 0 and `out_port` is all zeros.
- R2: `out_valid` equals the `req_valid` sampled at the previous rising clock edge. `out_port` reflects the inputs sampled at that same edge. While `out_valid` is 0, `out_port` is all zeros.
- R3: `out_port` is one-hot whenever `out_valid` is 1. The bit positions are: bit 0 local, bit 1 east, bit 2 west, bit 3 north, bit 4 south, bit 5 up, bit 6 down.
- R4: When the current x, y and z all equal the destination, the local port is requested, in either mode.
- R5: Whenever lateral movement is chosen, a differing x is resolved first (east if the current x is below the destination x, otherwise west). Only once x matches does a differing y select north (current y below) or south.
- R6: In lateral-first mode (`route_down` = 0), if x or y differs and the current layer equals `src_z`, a lateral port is requested.
- R7: In lateral-first mode, if x or y differs and the current layer is not `src_z`, the vertical port toward `src_z` is requested: up when `src_z` is above, down when below.
- R8: In downward mode (`route_down` = 1), if x or y differs and the current z is above 0, the down port is requested.
- R9: In downward mode, if x or y differs and the current z is 0, the lateral port is chosen by the R5 order.
- R10: In either mode, if x and y both match and z differs, up is requested when the destination layer is higher and down when it is lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| req_valid | input | 1 | A head flit's routing request is present this cycle |
| cur_x | input | $clog2(X_DIM) | This router's x coordinate |
| cur_y | input | $clog2(Y_DIM) | This router's y coordinate |
| cur_z | input | $clog2(Z_DIM) | This router's layer |
| dst_x | input | $clog2(X_DIM) | Destination x |
| dst_y | input | $clog2(Y_DIM) | Destination y |
| dst_z | input | $clog2(Z_DIM) | Destination layer |
| src_z | input | $clog2(Z_DIM) | Layer the packet was injected on |
| route_down | input | 1 | Path mode: 0 lateral-first, 1 downward |
| out_valid | output | 1 | Registered request valid |
| out_port | output | 7 | Registered one-hot output-port request |

## Verification
The embedded properties check on every cycle the framing of the output. That covers one-hot encoding, an idle vector of zeros, and valid following request by one cycle. They also check a set of safety rules. Down is never requested from the bottom layer, up is never requested from the top layer, and local is requested only on exact arrival. North or south appears only after x has matched. Which port is correct for a given mode, source layer and position depends on the full decision order. Only the bench's reference model shows this, by comparing every cycle across directed corners and varied inputs. Its hop-by-hop packet walks are the only evidence of whole-path properties: that each mode reaches its destination with the expected hop count.

// File: rtl/dm3d_route_pkg.sv
package dm3d_route_pkg;
  localparam int NUM_PORTS = 7;

  // Bit index of each port inside the one-hot request vector.
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4,
    PORT_UP    = 3'd5,
    PORT_DOWN  = 3'd6
  } port_e;
endpackage

// File: rtl/dm3d_lateral_step.sv
module dm3d_lateral_step
  import dm3d_route_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic          pending,
  output port_e         dir
);
  logic x_diff, y_diff;

  assign x_diff  = (cur_x != dst_x);
  assign y_diff  = (cur_y != dst_y);
  assign pending = x_diff | y_diff;

  // Dimension order: x is settled before y is looked at.
  always_comb begin
    if (x_diff)      dir = (cur_x < dst_x) ? PORT_EAST  : PORT_WEST;
    else if (y_diff) dir = (cur_y < dst_y) ? PORT_NORTH : PORT_SOUTH;
    else             dir = PORT_LOCAL;
  end
endmodule

// File: rtl/dm3d_vertical_step.sv
module dm3d_vertical_step
  import dm3d_route_pkg::*;
#(
  parameter int ZW = 2
) (
  input  logic [ZW-1:0] cur_z,
  input  logic [ZW-1:0] tgt_z,
  output logic          pending,
  output port_e         dir
);
  assign pending = (cur_z != tgt_z);

  always_comb begin
    if (cur_z < tgt_z)      dir = PORT_UP;
    else if (cur_z > tgt_z) dir = PORT_DOWN;
    else                    dir = PORT_LOCAL;
  end
endmodule

// File: rtl/dm3d_route_unit.sv
module dm3d_route_unit
  import dm3d_route_pkg::*;
#(
  parameter int X_DIM = 8,
  parameter int Y_DIM = 8,
  parameter int Z_DIM = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [$clog2(X_DIM)-1:0]   cur_x,
  input  logic [$clog2(Y_DIM)-1:0]   cur_y,
  input  logic [$clog2(Z_DIM)-1:0]   cur_z,
  input  logic [$clog2(X_DIM)-1:0]   dst_x,
  input  logic [$clog2(Y_DIM)-1:0]   dst_y,
  input  logic [$clog2(Z_DIM)-1:0]   dst_z,
  input  logic [$clog2(Z_DIM)-1:0]   src_z,
  input  logic                       route_down,
  output logic                       out_valid,
  output logic [NUM_PORTS-1:0]       out_port
);
  localparam int XW = $clog2(X_DIM);
  localparam int YW = $clog2(Y_DIM);
  localparam int ZW = $clog2(Z_DIM);
  localparam logic [ZW-1:0] Z_TOP = ZW'(Z_DIM - 1);
  localparam int N_VERT = 2; // 0: toward destination layer, 1: toward source layer

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Lateral (XY) candidate.
  logic  lat_pending;
  port_e lat_dir;
  dm3d_lateral_step #(.XW(XW), .YW(YW)) u_lat (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .pending(lat_pending), .dir(lat_dir)
  );

  // Vertical candidates.
  logic [ZW-1:0]     vert_tgt     [N_VERT];
  logic [N_VERT-1:0] vert_pending;
  port_e             vert_dir     [N_VERT];
  assign vert_tgt[0] = dst_z;
  assign vert_tgt[1] = src_z;

  for (genvar g = 0; g < N_VERT; g++) begin : g_vert
    dm3d_vertical_step #(.ZW(ZW)) u_vert (
      .cur_z(cur_z), .tgt_z(vert_tgt[g]),
      .pending(vert_pending[g]), .dir(vert_dir[g])
    );
  end

  // Mode-dependent selection.
  port_e sel_dir;
  always_comb begin
    sel_dir = PORT_LOCAL;
    if (lat_pending) begin
      if (route_down)           sel_dir = (cur_z != '0) ? PORT_DOWN : lat_dir;
      else if (vert_pending[1]) sel_dir = vert_dir[1];
      else                      sel_dir = lat_dir;
    end else if (vert_pending[0]) begin
      sel_dir = vert_dir[0];
    end
  end

  // Next state and output register.
  logic                 valid_d, valid_q;
  logic [NUM_PORTS-1:0] port_d, port_q;
  logic                 port_en;

  always_comb begin
    valid_d = req_valid;
    port_d  = '0;
    if (req_valid) port_d[sel_dir] = 1'b1;
    port_en = req_valid | valid_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      port_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (port_en) port_q <= port_d;
    end
  end

  assign out_valid = valid_q;
  assign out_port  = port_q;

  // R2
  follow_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> out_valid);
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> (out_port == '0));
  // R3
  onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> ($countones(out_port) == 1));
  // R4
  local_arrival_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_port[PORT_LOCAL]) |->
      $past(cur_x == dst_x && cur_y == dst_y && cur_z == dst_z));
  // R5
  x_before_y_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && (out_port[PORT_NORTH] || out_port[PORT_SOUTH])) |->
      $past(cur_x == dst_x));
  // R8
  no_down_at_floor_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_port[PORT_DOWN]) |-> ($past(cur_z) != '0));
  // R10
  no_up_at_top_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_port[PORT_UP]) |-> ($past(cur_z) != Z_TOP));
endmodule

// File: tb/dm3d_route_unit_tb.sv
module dm3d_route_unit_tb_top;
  localparam int X_DIM = 8;
  localparam int Y_DIM = 8;
  localparam int Z_DIM = 4;
  localparam int XW = $clog2(X_DIM);
  localparam int YW = $clog2(Y_DIM);
  localparam int ZW = $clog2(Z_DIM);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [XW-1:0] cur_x = '0, dst_x = '0;
  logic [YW-1:0] cur_y = '0, dst_y = '0;
  logic [ZW-1:0] cur_z = '0, dst_z = '0, src_z = '0;
  logic route_down = 1'b0;
  logic out_valid;
  logic [6:0] out_port;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  dm3d_route_unit #(.X_DIM(X_DIM), .Y_DIM(Y_DIM), .Z_DIM(Z_DIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
    .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z), .src_z(src_z),
    .route_down(route_down), .out_valid(out_valid), .out_port(out_port)
  );

  // Reference: returns port index 0..6.
  function automatic int ref_port(int cx, int cy, int cz, int dx, int dy, int dz,
                                  int sz, bit dn);
    if (cx == dx && cy == dy) begin
      if (dz > cz) return 5;
      if (dz < cz) return 6;
      return 0;
    end
    if (dn && cz > 0) return 6;
    if (!dn && cz != sz) return (sz > cz) ? 5 : 6;
    if (cx != dx) return (cx < dx) ? 1 : 2;
    return (cy < dy) ? 3 : 4;
  endfunction

  function automatic string req_tag(int cx, int cy, int cz, int dx, int dy, int dz,
                                    int sz, bit dn);
    if (cx == dx && cy == dy) return (cz == dz) ? "R4" : "R10";
    if (dn) return (cz > 0) ? "R8" : "R9";
    return (cz != sz) ? "R7" : "R6";
  endfunction

  task automatic check(string tag, logic [6:0] act_p, logic act_v,
                       logic [6:0] exp_p, logic exp_v);
    checks++;
    if (act_p !== exp_p || act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: valid=%0b port=%b expected valid=%0b port=%b",
               tag, act_v, act_p, exp_v, exp_p);
    end
  endtask

  // One cycle: drive at negedge, compare at the following negedge.
  task automatic hop(int cx, int cy, int cz, int dx, int dy, int dz, int sz,
                     bit dn, output int got);
    logic [6:0] exp_p;
    int e;
    @(negedge clk);
    req_valid = 1'b1;
    cur_x = XW'(cx); cur_y = YW'(cy); cur_z = ZW'(cz);
    dst_x = XW'(dx); dst_y = YW'(dy); dst_z = ZW'(dz);
    src_z = ZW'(sz); route_down = dn;
    e = ref_port(cx, cy, cz, dx, dy, dz, sz, dn);
    exp_p = 7'(1 << e);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_tag(cx, cy, cz, dx, dy, dz, sz, dn), out_port, out_valid, exp_p, 1'b1);
    got = -1;
    for (int i = 0; i < 7; i++) if (out_port[i]) got = i;
  endtask

  task automatic walk(int sx, int sy, int sz, int dx, int dy, int dz, bit dn);
    int cx = sx, cy = sy, cz = sz, hops = 0, p = -1, exp_h;
    for (int n = 0; n < 40 && p != 0; n++) begin
      hop(cx, cy, cz, dx, dy, dz, sz, dn, p);
      case (p)
        1: cx++; 2: cx--; 3: cy++; 4: cy--; 5: cz++; 6: cz--;
        default: ;
      endcase
      if (p != 0) hops++;
      if (p < 0) break;
    end
    if (dn && (sx != dx || sy != dy))
      exp_h = sz + dz + ((sx > dx) ? sx - dx : dx - sx) + ((sy > dy) ? sy - dy : dy - sy);
    else
      exp_h = ((sx > dx) ? sx - dx : dx - sx) + ((sy > dy) ? sy - dy : dy - sy)
            + ((sz > dz) ? sz - dz : dz - sz);
    checks++;
    if (p != 0 || hops != exp_h || cx != dx || cy != dy || cz != dz) begin
      errors++;
      $display("FAIL %s walk: hops=%0d end=(%0d,%0d,%0d) expected hops=%0d end=(%0d,%0d,%0d)",
               dn ? "R8/R9" : "R6", hops, cx, cy, cz, exp_h, dx, dy, dz);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int p;
    // R1: during reset
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    check("R1", out_port, out_valid, 7'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", out_port, out_valid, 7'd0, 1'b0);

    // Directed corners
    hop(3, 4, 2, 3, 4, 2, 0, 0, p);   // R4 lateral-first arrival
    hop(3, 4, 2, 3, 4, 2, 0, 1, p);   // R4 downward arrival
    hop(2, 5, 1, 6, 1, 3, 1, 0, p);   // R5/R6 east first
    hop(6, 5, 1, 2, 7, 3, 1, 0, p);   // R5 west first
    hop(4, 2, 1, 4, 6, 3, 1, 0, p);   // R5 north after x matched
    hop(4, 6, 0, 4, 2, 3, 0, 0, p);   // R5 south
    hop(1, 1, 1, 5, 5, 0, 3, 0, p);   // R7 up toward source layer
    hop(1, 1, 3, 5, 5, 0, 0, 0, p);   // R7 down toward source layer
    hop(1, 1, 3, 5, 5, 3, 3, 1, p);   // R8 descend first
    hop(1, 1, 0, 5, 5, 3, 3, 1, p);   // R9 east on floor
    hop(5, 1, 0, 5, 0, 3, 3, 1, p);   // R9 south on floor
    hop(5, 5, 0, 5, 5, 3, 3, 1, p);   // R10 climb
    hop(5, 5, 3, 5, 5, 1, 0, 0, p);   // R10 descend to lower destination
    hop(0, 0, 3, 7, 7, 3, 3, 0, p);   // R6 on top layer

    // R2: idle cycle gives zero vector and no valid
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R2", out_port, out_valid, 7'd0, 1'b0);
    @(negedge clk);
    check("R2", out_port, out_valid, 7'd0, 1'b0);

    // Varied inputs, R3 encoding checked on each
    for (int k = 0; k < 400; k++) begin
      hop($urandom_range(X_DIM-1), $urandom_range(Y_DIM-1), $urandom_range(Z_DIM-1),
          $urandom_range(X_DIM-1), $urandom_range(Y_DIM-1), $urandom_range(Z_DIM-1),
          $urandom_range(Z_DIM-1), 1'($urandom_range(1)), p);
    end

    // Whole-packet walks in both modes, including injection on the floor
    walk(0, 0, 0, 7, 7, 3, 1);
    walk(7, 0, 3, 0, 7, 2, 1);
    walk(2, 3, 2, 6, 1, 0, 0);
    walk(2, 3, 2, 2, 3, 0, 1);
    for (int k = 0; k < 60; k++) begin
      int sz = $urandom_range(Z_DIM-1);
      walk($urandom_range(X_DIM-1), $urandom_range(Y_DIM-1), sz,
           $urandom_range(X_DIM-1), $urandom_range(Y_DIM-1), $urandom_range(Z_DIM-1),
           1'($urandom_range(1)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule